// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block produces a divided clock as a train of one-cycle clock-enable pulses in the domain of its input clock. Logic downstream qualifies its flops with the pulse and does not use a derived clock. Software controls the block through a small write port and a combinational read port. A gate register holds a single enable bit at a position set by a parameter. A divisor register holds an integer field, and a status word shows whether a divisor change is still pending.

A divisor write does not act at once. It is held as pending and becomes active only where the running output period ends, so no shortened period ever appears. The status word shows two busy bits from the write until the change has taken effect. The intended flow is to poll the status word, write the divisor, then poll again. A divisor write that arrives while a change is still pending is dropped, and a sticky error bit records it. The field is 5 bits by default. A parameter widens it to 6 bits, and in that mode the top bit selects a fixed divide-by-64 prescale that multiplies the low 5 bits.

Top module: `clkdiv_gated`

## Requirements
- R1: After reset the gate is off, the divisor field reads 0, the status word reads 0 and `tick_o` is low.
- R2: With the gate on and an effective divisor N, `tick_o` is high for exactly one cycle in every N cycles. The first pulse comes in the N-th cycle after the edge that turns the gate on. N=1 gives a pulse in every cycle.
- R3: A divisor field of 0 selects a divisor of 2^DIV_W: 32 in 5-bit mode and 64 in 6-bit mode.
- R4: In 6-bit mode, a field with bit 5 set selects a divisor of 64 times bits 4:0, and a zero low part selects 64. With bit 5 clear, bits 4:0 are a plain divisor from 1 to 31.
- R5: Address 1 is the gate register. Its enable is bit GATE_BIT, and the register reads back the current gate state at that bit. With the gate off, no pulses are produced and the period counter is cleared, so after the gate is turned on again the first pulse comes a full N cycles later.
- R6: An accepted divisor takes effect on the edge after the cycle that carries the last pulse of the running period, so the running period always completes. With the gate off, it takes effect on the next edge.
- R7: Status (address 0) bits 4 and 3 both read 1 from the edge of an accepted divisor write until the edge where the new divisor takes effect.
- R8: A divisor write (address 2) made while busy is set leaves the divisor unchanged and sets status bit 0. Bit 0 stays set until a write to address 0 with bit 0 set.
- R9: Reading address 2 returns the last accepted divisor field, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 status, 1 gate, 2 divisor |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | DATA_W | Combinational read data |
| tick_o | output | 1 | One-cycle clock-enable pulse at the divided rate |

## Verification
The hardest case to reach is a divisor write that lands while an earlier change is still waiting for its period boundary. The write must be dropped, the error bit must be set, and the period must still switch at the right edge. The bench reaches this case by waiting for an observed pulse under a short divisor. It then issues two divisor writes on consecutive edges, so the second one falls inside the pending window. Counter clearing is shown by turning the gate off and on again in the middle of a period, then checking that the next pulse comes a full period later.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_GATE = 2'd1,
    REG_DIV  = 2'd2
  } reg_addr_e;

  localparam int ERR_BIT  = 0;
  localparam int BUSY_LO  = 3;
  localparam int BUSY_HI  = 4;
  localparam int PRE_SH   = 6;  // prescale factor 2**PRE_SH in wide mode
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 5,
  parameter int GATE_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  input  logic              apply_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              gate_o,
  output logic              pend_o,
  output logic              err_o,
  output logic [DIV_W-1:0]  field_o
);
  logic div_wr, stat_wr, gate_wr;

  assign div_wr  = wr_en_i && (wr_addr_i == REG_DIV);
  assign stat_wr = wr_en_i && (wr_addr_i == REG_STAT);
  assign gate_wr = wr_en_i && (wr_addr_i == REG_GATE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_o  <= 1'b0;
      pend_o  <= 1'b0;
      err_o   <= 1'b0;
      field_o <= '0;
    end else begin
      if (apply_i) pend_o <= 1'b0;
      if (div_wr) begin
        if (pend_o) begin
          err_o <= 1'b1;
        end else begin
          field_o <= wr_data_i[DIV_W-1:0];
          pend_o  <= 1'b1;
        end
      end
      if (stat_wr && wr_data_i[ERR_BIT]) err_o <= 1'b0;
      if (gate_wr) gate_o <= wr_data_i[GATE_BIT];
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_STAT: begin
        rd_data_o[ERR_BIT] = err_o;
        rd_data_o[BUSY_LO] = pend_o;
        rd_data_o[BUSY_HI] = pend_o;
      end
      REG_GATE: rd_data_o[GATE_BIT] = gate_o;
      REG_DIV:  rd_data_o[DIV_W-1:0] = field_o;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int CNT_W = 6
) (
  input  logic [DIV_W-1:0] field_i,
  output logic [CNT_W-1:0] n_o
);
  localparam bit WIDE = (DIV_W == 6);

  generate
    if (WIDE) begin : g_wide
      logic [DIV_W-2:0] low;
      assign low = field_i[DIV_W-2:0];
      always_comb begin
        if (field_i[DIV_W-1]) begin
          if (low == '0) n_o = CNT_W'(2 ** PRE_SH);
          else           n_o = CNT_W'(low) << PRE_SH;
        end else if (low == '0) begin
          n_o = CNT_W'(2 ** DIV_W);
        end else begin
          n_o = CNT_W'(low);
        end
      end
    end else begin : g_plain
      always_comb begin
        if (field_i == '0) n_o = CNT_W'(2 ** DIV_W);
        else               n_o = CNT_W'(field_i);
      end
    end
  endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int CNT_W = 6,
  parameter int RST_N = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             pend_i,
  input  logic [CNT_W-1:0] n_new_i,
  output logic             tick_o,
  output logic             apply_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_n_o
);
  logic boundary;

  assign tick_o   = gate_i && (cnt_o == act_n_o - 1'b1);
  assign boundary = tick_o || !gate_i;
  assign apply_o  = pend_i && boundary;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      act_n_o <= CNT_W'(RST_N);
    end else begin
      if (apply_o) act_n_o <= n_new_i;
      if (boundary) cnt_o <= '0;
      else          cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated #(
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 5,
  parameter int GATE_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tick_o
);
  localparam bit WIDE  = (DIV_W == 6);
  localparam int NMAX  = WIDE ? 64 * 31 : 2 ** DIV_W;
  localparam int CNT_W = $clog2(NMAX + 1);
  localparam int RST_N = 2 ** DIV_W;

  logic             gate, pend, err, apply;
  logic [DIV_W-1:0] field;
  logic [CNT_W-1:0] n_new, cnt, act_n;

  clkdiv_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .GATE_BIT(GATE_BIT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .apply_i   (apply),
    .rd_data_o (rd_data_o),
    .gate_o    (gate),
    .pend_o    (pend),
    .err_o     (err),
    .field_o   (field)
  );

  clkdiv_decode #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dec (
    .field_i (field),
    .n_o     (n_new)
  );

  clkdiv_counter #(.CNT_W(CNT_W), .RST_N(RST_N)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gate_i  (gate),
    .pend_i  (pend),
    .n_new_i (n_new),
    .tick_o  (tick_o),
    .apply_o (apply),
    .cnt_o   (cnt),
    .act_n_o (act_n)
  );
endmodule

// File: rtl/clkdiv_gated_chk.sv
module clkdiv_gated_chk
  import clkdiv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 5,
  parameter int CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              tick_o,
  input logic              gate,
  input logic              pend,
  input logic              err,
  input logic [DIV_W-1:0]  field,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  act_n
);
  p_no_tick_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> gate);

  p_cnt_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate |=> (cnt == '0));

  p_cnt_in_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate |-> (cnt < act_n));

  p_no_midperiod_switch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate && !tick_o) |=> $stable(act_n));

  p_busy_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_DIV && !pend) |=>
      (pend && field == $past(wr_data_i[DIV_W-1:0])));

  p_drop_when_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_DIV && pend) |=> (err && $stable(field)));

  p_err_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_STAT && wr_data_i[ERR_BIT]) |=> !err);
endmodule

bind clkdiv_gated clkdiv_gated_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .tick_o    (tick_o),
  .gate      (gate),
  .pend      (pend),
  .err       (err),
  .field     (field),
  .cnt       (cnt),
  .act_n     (act_n)
);

// File: tb/sim_clkdiv_gated.sv
`timescale 1ns/1ps
module sim_clkdiv_gated;
  localparam int GB0 = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  wa [2];
  logic [1:0]  ra [2];
  logic        we [2];
  logic [31:0] wd [2];
  logic [31:0] rd [2];
  logic        tk [2];

  clkdiv_gated #(.DIV_W(6), .GATE_BIT(GB0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we[0]), .wr_addr_i(wa[0]),
    .wr_data_i(wd[0]), .rd_addr_i(ra[0]), .rd_data_o(rd[0]), .tick_o(tk[0]));

  clkdiv_gated u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we[1]), .wr_addr_i(wa[1]),
    .wr_data_i(wd[1]), .rd_addr_i(ra[1]), .rd_data_o(rd[1]), .tick_o(tk[1]));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_q[$];
  int t;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor for u0 pulses
  always @(negedge clk) begin
    if (rst_n && tk[0]) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R2 pulse cycle", cyc, e);
      end
    end
  end

  // caller sits at a negedge; write edge = cyc on return
  task automatic wr(input int s, input logic [1:0] a, input logic [31:0] d);
    we[s] = 1'b1; wa[s] = a; wd[s] = d;
    @(negedge clk);
    we[s] = 1'b0; wd[s] = '0;
  endtask

  task automatic rd_chk(input int s, input logic [1:0] a, input int exp, input string req);
    ra[s] = a;
    #1;
    chk(rd[s] == 32'(exp), req, int'(rd[s]), exp);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push_train(input int first, input int n, input int cnt);
    for (int k = 0; k < cnt; k++) exp_q.push_back(first + k * n);
  endtask

  // at a pulse cycle t: change divisor, old period completes, then new ones
  task automatic chg(input int n_old, input int field, input int n_new, input int cnt);
    wr(0, 2'd2, 32'(field));
    exp_q.push_back(t + n_old);
    push_train(t + n_old + n_new, n_new, cnt);
    t = t + n_old + cnt * n_new;
    wait_cyc(t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int g;
    for (int s = 0; s < 2; s++) begin
      we[s] = 1'b0; wa[s] = '0; wd[s] = '0; ra[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state on both instances
    for (int s = 0; s < 2; s++) begin
      rd_chk(s, 2'd0, 0, "R1 status");
      rd_chk(s, 2'd1, 0, "R1 gate");
      rd_chk(s, 2'd2, 0, "R1 divisor");
      chk(tk[s] == 1'b0, "R1 tick low", int'(tk[s]), 0);
    end

    // R3 5-bit mode: field 0 divides by 32
    wr(1, 2'd1, 32'h1);
    g = cyc;
    wait_cyc(g + 30); chk(tk[1] == 1'b0, "R3 5-bit no early pulse", int'(tk[1]), 0);
    wait_cyc(g + 31); chk(tk[1] == 1'b1, "R3 5-bit first pulse", int'(tk[1]), 1);
    wait_cyc(g + 32); chk(tk[1] == 1'b0, "R3 5-bit single cycle", int'(tk[1]), 0);
    wait_cyc(g + 63); chk(tk[1] == 1'b1, "R3 5-bit second pulse", int'(tk[1]), 1);
    wr(1, 2'd1, 32'h0);

    // R6/R7 with the gate off the change applies on the next edge
    wr(0, 2'd2, 32'd3);
    rd_chk(0, 2'd0, 32'h18, "R7 busy after write");
    @(negedge clk);
    rd_chk(0, 2'd0, 0, "R6 gate-off change immediate");
    rd_chk(0, 2'd2, 3, "R9 divisor readback");

    // R2/R5 gate on, N=3
    wr(0, 2'd1, 32'(1 << GB0));
    g = cyc;
    rd_chk(0, 2'd1, 1 << GB0, "R5 gate readback");
    push_train(g + 2, 3, 4);
    t = g + 11;
    wait_cyc(t);

    // R6/R7/R8 change to 5 then a dropped write to 7
    wr(0, 2'd2, 32'd5);
    exp_q.push_back(t + 3);
    push_train(t + 8, 5, 3);
    rd_chk(0, 2'd0, 32'h18, "R7 busy set");
    wr(0, 2'd2, 32'd7);
    rd_chk(0, 2'd0, 32'h19, "R8 error on busy write");
    wait_cyc(t + 3);
    rd_chk(0, 2'd0, 32'h19, "R7 busy until boundary");
    wait_cyc(t + 4);
    rd_chk(0, 2'd0, 32'h01, "R7 busy cleared after boundary");
    rd_chk(0, 2'd2, 5, "R8 dropped write left divisor");
    wr(0, 2'd0, 32'h1);
    rd_chk(0, 2'd0, 0, "R8 error cleared");
    t = t + 18;
    wait_cyc(t);

    // R4 prescale, R3 zero field in 6-bit mode, R2 N=1
    chg(5,   'h21, 64,  2);
    chg(64,  'h22, 128, 1);
    chg(128, 'h20, 64,  1);
    chg(64,  'h00, 64,  1);
    chg(64,  'h01, 1,   5);

    // R5 gate off: no pulses
    wr(0, 2'd1, 32'h0);
    rd_chk(0, 2'd1, 0, "R5 gate cleared readback");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all pulses seen", exp_q.size(), 0);

    // R6 change with gate off, N=4
    wr(0, 2'd2, 32'd4);
    rd_chk(0, 2'd0, 32'h18, "R7 busy gate off");
    @(negedge clk);
    rd_chk(0, 2'd0, 0, "R6 applied gate off");

    // R5 counter cleared by a mid-period gate off
    wr(0, 2'd1, 32'(1 << GB0));
    g = cyc;
    push_train(g + 3, 4, 2);
    wait_cyc(g + 9);
    wr(0, 2'd1, 32'h0);
    wr(0, 2'd1, 32'(1 << GB0));
    g = cyc;
    push_train(g + 3, 4, 2);
    wait_cyc(g + 7);
    wr(0, 2'd1, 32'h0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 restart pulses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule